// File: doc/BRIEF.md
# Digital Loopback Mix Attenuator

This block adds an attenuated copy of the capture (ADC) stream to the playback (DAC) stream once per stereo sample period. On each sample strobe it picks a capture operand and a playback operand for each channel, scales the capture operand by a 6-bit attenuation code in 1.5 dB steps, adds the two, clips the sum to the signed 16-bit range and registers the result as the next DAC sample.

The operands follow fixed substitution rules. While the capture side reports an overrun, the block uses the last capture sample it accepted. While the playback side reports an underrun, it uses either midscale zero or the last valid playback sample, depending on a control bit. When playback is disabled the playback operand is zero, but capture data is still mixed in if the mix is enabled. Both channels use the same code and are otherwise independent.

Top module: `loopback_mixer`

## Requirements
- R1: While rst is high, and after it, until the first strobe, dac_l and dac_r are 0, and the held capture and held playback samples of both channels are 0.
- R2: dac_l and dac_r change only on a rising clk edge at which smp_stb is 1, and then show that sample's result. With smp_stb at 0 they hold their value whatever the other inputs do.
- R3: With code c, the attenuated capture value is floor((x >>> (c div 4)) * M / 32768), where M is 32768, 27571, 23197 or 19520 for c mod 4 = 0, 1, 2 or 3. Code 0 passes x unchanged, and code 63 gives -94.5 dB.
- R4: With mix_en at 0, the capture contribution is zero and the output is the playback operand alone.
- R5: With play_en at 0, the playback operand is zero and the attenuated capture is still mixed in when mix_en is 1.
- R6: On a strobe with cap_ovr at 1, the capture operand is the last capture sample strobed in with cap_ovr at 0 (0 if there was none). A strobe with cap_ovr at 0 uses the live sample and stores it.
- R7: On a strobe with play_en at 1, play_ur at 1 and zero_on_ur at 1, the playback operand is 0.
- R8: On a strobe with play_en at 1, play_ur at 1 and zero_on_ur at 0, the playback operand is the last playback sample strobed in with play_en at 1 and play_ur at 0 (0 if there was none).
- R9: The sum of the playback operand and the attenuated capture saturates to 32767 or -32768 and does not wrap.
- R10: The left and right channels use the same code and never affect each other's result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| smp_stb | input | 1 | One-cycle strobe per stereo sample period |
| mix_en | input | 1 | Enables the loopback mix |
| atten_code | input | 6 | Attenuation code, 1.5 dB per step |
| zero_on_ur | input | 1 | Selects midscale zero (1) or repeat (0) on underrun |
| play_en | input | 1 | Playback enabled |
| cap_l | input | 16 | Left capture sample, signed |
| cap_r | input | 16 | Right capture sample, signed |
| cap_ovr | input | 1 | Capture overrun flag |
| play_l | input | 16 | Left playback sample, signed |
| play_r | input | 16 | Right playback sample, signed |
| play_ur | input | 1 | Playback underrun flag |
| dac_l | output | 16 | Left mixed DAC sample, signed |
| dac_r | output | 16 | Right mixed DAC sample, signed |

## Verification
A stale or corrupted held capture or playback sample stays hidden until an overrun or an underrun in repeat mode selects it. It then shows up at the output register on that same strobe edge, so the bench stores a known value first and then forces each substitution. A wrong mantissa or shift shows up as soon as the output of the strobe that uses that code is registered, so the bench sweeps all 64 codes at two amplitudes of opposite sign. A missing clip appears only when the sum crosses full scale, which the bench drives in both directions.

// File: rtl/lbmix_pkg.sv
package lbmix_pkg;

    localparam int SMP_W  = 16;
    localparam int CODE_W = 6;
    localparam int FRAC_W = 15;
    localparam int MANT_W = FRAC_W + 2;

    typedef logic signed [SMP_W-1:0] sample_t;

    // Where the playback operand of a sample comes from
    typedef enum logic [1:0] {
        PSRC_LIVE = 2'd0,
        PSRC_HOLD = 2'd1,
        PSRC_ZERO = 2'd2
    } play_src_e;

    // Inputs of one channel, gathered on one strobe
    typedef struct packed {
        sample_t cap;
        sample_t play;
    } chan_in_t;

    // Unsigned Q15 scale factor for the fine quarter of the 6 dB octave
    function automatic logic [MANT_W-1:0] fine_gain(input logic [1:0] step);
        logic [MANT_W-1:0] g;
        case (step)
            2'd0:    g = MANT_W'(32768);
            2'd1:    g = MANT_W'(27571);
            2'd2:    g = MANT_W'(23197);
            default: g = MANT_W'(19520);
        endcase
        return g;
    endfunction

    function automatic play_src_e pick_play_src(input logic en,
                                                input logic under,
                                                input logic zero_sel);
        play_src_e s;
        if (!en)
            s = PSRC_ZERO;
        else if (!under)
            s = PSRC_LIVE;
        else if (zero_sel)
            s = PSRC_ZERO;
        else
            s = PSRC_HOLD;
        return s;
    endfunction

endpackage

// File: rtl/lb_atten.sv
module lb_atten
    import lbmix_pkg::*;
#(
    parameter int SW = SMP_W,
    parameter int CW = CODE_W
) (
    input  logic signed [SW-1:0] din,
    input  logic        [CW-1:0] code,
    output logic signed [SW-1:0] dout
);
    localparam int PROD_W = SW + MANT_W + 1;

    logic signed [SW-1:0]     coarse;
    logic signed [MANT_W:0]   gain_s;
    logic signed [PROD_W-1:0] prod;

    always_comb begin
        // 6 dB per group of four codes
        coarse = din >>> code[CW-1:2];
        gain_s = $signed({1'b0, fine_gain(code[1:0])});
        prod   = PROD_W'(coarse) * PROD_W'(gain_s);
        // the floor of prod / 2^FRAC_W always fits in SW bits (gain <= 1)
        dout   = prod[FRAC_W +: SW];
    end

endmodule

// File: rtl/lb_channel.sv
module lb_channel
    import lbmix_pkg::*;
#(
    parameter int SW = SMP_W,
    parameter int CW = CODE_W
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 stb,
    input  logic                 mix_en,
    input  logic        [CW-1:0] code,
    input  logic                 zero_on_ur,
    input  logic                 play_en,
    input  logic                 cap_ovr,
    input  logic                 play_ur,
    input  logic signed [SW-1:0] cap,
    input  logic signed [SW-1:0] play,
    output logic signed [SW-1:0] dac
);
    localparam logic signed [SW:0] POS_LIM = (SW+1)'((1 << (SW-1)) - 1);
    localparam logic signed [SW:0] NEG_LIM = -(SW+1)'(1 << (SW-1));

    logic signed [SW-1:0] cap_hold, play_hold;
    logic signed [SW-1:0] cap_op, play_op, cap_att, mix_op;
    logic signed [SW:0]   sum;
    logic signed [SW-1:0] clipped;
    play_src_e            psrc;

    always_comb begin
        cap_op = cap_ovr ? cap_hold : cap;
        psrc   = pick_play_src(play_en, play_ur, zero_on_ur);
        case (psrc)
            PSRC_LIVE: play_op = play;
            PSRC_HOLD: play_op = play_hold;
            default:   play_op = '0;
        endcase
    end

    lb_atten #(.SW(SW), .CW(CW)) u_atten (
        .din  (cap_op),
        .code (code),
        .dout (cap_att)
    );

    always_comb begin
        mix_op = mix_en ? cap_att : '0;
        sum    = {play_op[SW-1], play_op} + {mix_op[SW-1], mix_op};
        if (sum > POS_LIM)
            clipped = POS_LIM[SW-1:0];
        else if (sum < NEG_LIM)
            clipped = NEG_LIM[SW-1:0];
        else
            clipped = sum[SW-1:0];
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            cap_hold  <= '0;
            play_hold <= '0;
            dac       <= '0;
        end else if (stb) begin
            dac <= clipped;
            if (!cap_ovr)
                cap_hold <= cap;
            if (psrc == PSRC_LIVE)
                play_hold <= play;
        end
    end

endmodule

// File: rtl/loopback_mixer.sv
module loopback_mixer
    import lbmix_pkg::*;
#(
    parameter int SW    = SMP_W,
    parameter int CW    = CODE_W,
    parameter int N_CH  = 2
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 smp_stb,
    input  logic                 mix_en,
    input  logic        [CW-1:0] atten_code,
    input  logic                 zero_on_ur,
    input  logic                 play_en,
    input  logic signed [SW-1:0] cap_l,
    input  logic signed [SW-1:0] cap_r,
    input  logic                 cap_ovr,
    input  logic signed [SW-1:0] play_l,
    input  logic signed [SW-1:0] play_r,
    input  logic                 play_ur,
    output logic signed [SW-1:0] dac_l,
    output logic signed [SW-1:0] dac_r
);
    logic signed [SW-1:0] cap_v  [N_CH];
    logic signed [SW-1:0] play_v [N_CH];
    logic signed [SW-1:0] dac_v  [N_CH];

    assign cap_v[0]  = cap_l;
    assign cap_v[1]  = cap_r;
    assign play_v[0] = play_l;
    assign play_v[1] = play_r;
    assign dac_l     = dac_v[0];
    assign dac_r     = dac_v[1];

    for (genvar ch = 0; ch < N_CH; ch++) begin : g_ch
        lb_channel #(.SW(SW), .CW(CW)) u_chan (
            .clk        (clk),
            .rst        (rst),
            .stb        (smp_stb),
            .mix_en     (mix_en),
            .code       (atten_code),
            .zero_on_ur (zero_on_ur),
            .play_en    (play_en),
            .cap_ovr    (cap_ovr),
            .play_ur    (play_ur),
            .cap        (cap_v[ch]),
            .play       (play_v[ch]),
            .dac        (dac_v[ch])
        );
    end

endmodule

// File: rtl/loopback_mixer_chk.sv
module loopback_mixer_chk #(
    parameter int SW = 16,
    parameter int CW = 6
) (
    input logic                 clk,
    input logic                 rst,
    input logic                 smp_stb,
    input logic                 mix_en,
    input logic        [CW-1:0] atten_code,
    input logic                 zero_on_ur,
    input logic                 play_en,
    input logic signed [SW-1:0] cap_l,
    input logic                 cap_ovr,
    input logic signed [SW-1:0] play_l,
    input logic                 play_ur,
    input logic signed [SW-1:0] dac_l,
    input logic signed [SW-1:0] dac_r
);
    // R2
    hold_between_strobes_chk: assert property (@(posedge clk) disable iff (rst)
        !smp_stb |=> ($stable(dac_l) && $stable(dac_r)));

    // R4
    mute_passes_playback_chk: assert property (@(posedge clk) disable iff (rst)
        (smp_stb && !mix_en && play_en && !play_ur) |=> (dac_l == $past(play_l)));

    // R5
    no_play_no_mix_zero_chk: assert property (@(posedge clk) disable iff (rst)
        (smp_stb && !mix_en && !play_en) |=> (dac_l == '0 && dac_r == '0));

    // R7
    underrun_zero_chk: assert property (@(posedge clk) disable iff (rst)
        (smp_stb && !mix_en && play_en && play_ur && zero_on_ur)
        |=> (dac_l == '0 && dac_r == '0));

    // R3
    unity_code_chk: assert property (@(posedge clk) disable iff (rst)
        (smp_stb && mix_en && atten_code == '0 && !play_en && !cap_ovr)
        |=> (dac_l == $past(cap_l)));

endmodule

bind loopback_mixer loopback_mixer_chk #(.SW(SW), .CW(CW)) u_chk (
    .clk        (clk),
    .rst        (rst),
    .smp_stb    (smp_stb),
    .mix_en     (mix_en),
    .atten_code (atten_code),
    .zero_on_ur (zero_on_ur),
    .play_en    (play_en),
    .cap_l      (cap_l),
    .cap_ovr    (cap_ovr),
    .play_l     (play_l),
    .play_ur    (play_ur),
    .dac_l      (dac_l),
    .dac_r      (dac_r)
);

// File: tb/loopback_mixer_bench.sv
module loopback_mixer_bench;
    localparam int CLK_P = 10;

    logic               clk = 1'b0;
    logic               rst = 1'b1;
    logic               smp_stb = 1'b0;
    logic               mix_en = 1'b0;
    logic [5:0]         atten_code = '0;
    logic               zero_on_ur = 1'b0;
    logic               play_en = 1'b0;
    logic signed [15:0] cap_l = '0, cap_r = '0, play_l = '0, play_r = '0;
    logic               cap_ovr = 1'b0, play_ur = 1'b0;
    logic signed [15:0] dac_l, dac_r;

    loopback_mixer u_loopback_mixer (
        .clk(clk), .rst(rst), .smp_stb(smp_stb), .mix_en(mix_en),
        .atten_code(atten_code), .zero_on_ur(zero_on_ur), .play_en(play_en),
        .cap_l(cap_l), .cap_r(cap_r), .cap_ovr(cap_ovr),
        .play_l(play_l), .play_r(play_r), .play_ur(play_ur),
        .dac_l(dac_l), .dac_r(dac_r)
    );

    always #(CLK_P/2) clk = ~clk;

    typedef struct {
        int    l;
        int    r;
        string tag;
    } exp_t;

    exp_t exp_q[$];
    int   n_chk = 0, n_bad = 0;
    int   last_l = 0, last_r = 0;
    int   m_cap_l = 0, m_cap_r = 0, m_play_l = 0, m_play_r = 0;
    bit   done = 1'b0;

    task automatic check(input int act, input int expv, input string tag);
        n_chk++;
        if (act != expv) begin
            n_bad++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, expv);
        end
    endtask

    // R3 model: coarse shift by code/4, then fine Q15 gain, floor
    function automatic int att_model(input int x, input int code);
        int     gains[4] = '{32768, 27571, 23197, 19520};
        longint p;
        p = longint'(x >>> (code / 4)) * longint'(gains[code % 4]);
        return int'(p >>> 15);
    endfunction

    function automatic int clip(input int v);
        if (v > 32767) return 32767;
        if (v < -32768) return -32768;
        return v;
    endfunction

    task automatic drive(input bit pe, input int pl, input int pr, input bit pur,
                         input int cl, input int cr, input bit covr,
                         input bit men, input int code, input bit zu,
                         input string tag);
        int   cop_l, cop_r, pop_l, pop_r, a_l, a_r;
        exp_t e;
        play_en = pe; play_l = 16'(pl); play_r = 16'(pr); play_ur = pur;
        cap_l = 16'(cl); cap_r = 16'(cr); cap_ovr = covr;
        mix_en = men; atten_code = 6'(code); zero_on_ur = zu;
        smp_stb = 1'b1;
        cop_l = covr ? m_cap_l : cl;
        cop_r = covr ? m_cap_r : cr;
        if (!pe)          begin pop_l = 0;        pop_r = 0;        end
        else if (!pur)    begin pop_l = pl;       pop_r = pr;       end
        else if (zu)      begin pop_l = 0;        pop_r = 0;        end
        else              begin pop_l = m_play_l; pop_r = m_play_r; end
        a_l = men ? att_model(cop_l, code) : 0;
        a_r = men ? att_model(cop_r, code) : 0;
        e.l = clip(pop_l + a_l);
        e.r = clip(pop_r + a_r);
        e.tag = tag;
        exp_q.push_back(e);
        if (!covr) begin m_cap_l = cl; m_cap_r = cr; end
        if (pe && !pur) begin m_play_l = pl; m_play_r = pr; end
        @(negedge clk);
        smp_stb = 1'b0;
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) begin
            cap_l = 16'(i * 777); play_l = 16'(-i * 311); cap_r = 16'(i);
            mix_en = i[0]; play_en = ~i[0]; atten_code = 6'(i);
            @(negedge clk);
        end
    endtask

    // Monitor: scoreboard pop on strobe edges, hold check otherwise
    initial begin
        bit st;
        exp_t e;
        wait (!rst);
        forever begin
            @(posedge clk);
            st = smp_stb;
            @(negedge clk);
            if (st) begin
                if (exp_q.size() == 0) begin
                    check(1, 0, "R2 unexpected strobe");
                end else begin
                    e = exp_q.pop_front();
                    check(int'(dac_l), e.l, {e.tag, " left"});
                    check(int'(dac_r), e.r, {e.tag, " right"});
                    last_l = e.l; last_r = e.r;
                end
            end else begin
                check(int'(dac_l), last_l, "R2 hold left");
                check(int'(dac_r), last_r, "R2 hold right");
            end
        end
    end

    initial begin
        #(CLK_P * 100000);
        if (!done) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog: actual hung expected finish");
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        check(int'(dac_l), 0, "R1 reset left");
        check(int'(dac_r), 0, "R1 reset right");
        rst = 1'b0;
        @(negedge clk);
        // R1/R6: overrun before any accepted capture uses zero hold
        drive(1, 100, -50, 0, 1000, 2000, 1, 1, 0, 0, "R1 R6 empty hold");
        // R8: underrun repeat with playback hold captured above
        drive(1, 7, 7, 1, 0, 0, 0, 0, 0, 0, "R8 repeat first");
        // R3, R10: unity code, distinct channels
        drive(1, 100, 200, 0, 1000, -2000, 0, 1, 0, 0, "R3 R10 unity");
        // R3: sweep every code at two amplitudes
        for (int c = 0; c < 64; c++)
            drive(0, 0, 0, 0, 30000, -30001, 0, 1, c, 0, "R3 sweep");
        drive(1, 0, 0, 0, -32768, 32767, 0, 1, 1, 0, "R3 extremes");
        // R4: mute
        drive(1, 555, -555, 0, 20000, 20000, 0, 0, 0, 0, "R4 mute");
        // R5: playback disabled, capture still mixed
        drive(0, 9999, 9999, 0, 4000, -4000, 0, 1, 4, 0, "R5 play off");
        drive(0, 9999, 9999, 0, 4000, -4000, 0, 0, 4, 0, "R5 play off mute");
        // R6: held capture during overrun
        drive(0, 0, 0, 0, 8000, -6000, 0, 1, 0, 0, "R6 store");
        drive(0, 0, 0, 0, 1, 1, 1, 1, 0, 0, "R6 overrun");
        drive(0, 0, 0, 0, 3, 3, 1, 1, 2, 0, "R6 overrun code2");
        // R7/R8: underrun
        drive(1, 1234, -4321, 0, 0, 0, 0, 0, 0, 0, "R8 store");
        drive(1, 5, 5, 1, 0, 0, 0, 0, 0, 1, "R7 zero");
        drive(1, 5, 5, 1, 0, 0, 0, 0, 0, 0, "R8 repeat");
        drive(1, 5, 5, 1, 1000, 1000, 0, 1, 8, 0, "R8 repeat mixed");
        // R9: saturation both ways
        drive(1, 30000, -30000, 0, 30000, -30000, 0, 1, 0, 0, "R9 clip");
        drive(1, -32768, 32767, 0, -1, 1, 0, 1, 0, 0, "R9 clip edge");
        // R2: hold across idle cycles
        idle(6);
        drive(1, 1, 2, 0, 0, 0, 0, 0, 0, 0, "R2 after idle");
        idle(2);
        check(exp_q.size(), 0, "R2 scoreboard drained");
        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

endmodule